// File: doc/BRIEF.md
# Packed Unsigned Byte-Add Execution Slice

This block is one execution slice of a processor core. It handles a single instruction that adds two 32-bit operands as four separate unsigned bytes. Each byte sum wraps inside its own lane. The carry out of each lane goes to the matching bit of the four-bit greater-or-equal flag group, called GE. The slice receives a raw instruction word, a select for the fixed-width or compact encoding, the two operand values read from the register file, and the current NZCV and GE flags. It recognises the encoding and evaluates the condition field. One clock later it presents a registered destination write and the next GE value.

A word that matches neither bit pattern raises an undefined-instruction output. So does a fixed-width word with the reserved condition code. In both cases nothing is written. An instruction whose condition fails also has no effect: the write enable stays low and GE is passed through unchanged. The register-index fields for the two sources are not decoded, because the operand values arrive already read from the register file. Only the destination index is extracted.

Top module: `pbadd_unit`

## Requirements
- R1: Result byte i (bits 8i+7:8i of `wr_data`) is the low 8 bits of the sum of byte i of `src_a` and byte i of `src_b`. No carry passes from one lane into the next.
- R2: On an executed instruction, `ge_out[i]` is 1 exactly when the 9-bit sum of lane i is 0x100 or more, and 0 otherwise. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R3: `nzcv_out` is the `flags_nzcv` value of the most recent valid input, unchanged. The operation never alters N, Z, C or V.
- R4: With `isa_compact`=0, the word matches when bits 27:20 = 0x65, bits 11:8 = 0xF and bits 7:4 = 0x9. The destination index is bits 15:12 and the condition is bits 31:28.
- R5: With `isa_compact`=1, the word matches when bits 31:20 = 0xFA8, bits 15:12 = 0xF and bits 7:4 = 0x4. The destination index is bits 11:8. A matching compact word always executes, whatever the NZCV value.
- R6: The condition code is evaluated on NZCV, with N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 always. When the condition fails, `wr_en`=0 and `undef`=0, and `ge_out` equals `ge_in`.
- R7: A word that does not match, or a fixed-width word with condition 0xF, gives `undef`=1 and `wr_en`=0, and `ge_out` equals `ge_in`.
- R8: The results of a valid input appear at the outputs one clock later. A cycle with `in_valid`=0 gives `wr_en`=0 and `undef`=0 one clock later, and `ge_out` keeps its value.
- R9: While `rst_n` is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| isa_compact | input | 1 | 0 = fixed-width encoding, 1 = compact encoding |
| insn | input | 32 | Instruction word |
| src_a | input | 32 | First operand value |
| src_b | input | 32 | Second operand value |
| flags_nzcv | input | 4 | Current N, Z, C, V (bits 3..0) |
| ge_in | input | 4 | Current GE flags |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 4 | Destination register index |
| wr_data | output | 32 | Destination write data |
| ge_out | output | 4 | Next GE flags |
| nzcv_out | output | 4 | Next NZCV flags (pass-through) |
| undef | output | 1 | Undefined-instruction indication |

## Verification
On every cycle, the assertions check the following:
- Each lane's carry agrees with its wrapped result.
- A write is never raised together with `undef`.
- Idle cycles leave the outputs quiet and GE held.
- NZCV is copied through unchanged.
- A skipped instruction passes GE through.

Only the bench scenarios can show the following:
- The exact byte sums and GE patterns, including a single carrying lane that must not disturb its neighbours.
- The outcome of all fifteen condition codes against every NZCV value.
- That flipping any single fixed bit of either encoding is detected.

// File: rtl/pbadd_pkg.sv
// Shared constants for the packed byte-add slice.
// Assumes a 32-bit word split into equal unsigned lanes.
package pbadd_pkg;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int XLEN    = LANES * LANE_W;
    localparam int IDX_W   = 4;
    localparam int FLAG_N  = 3;
    localparam int FLAG_Z  = 2;
    localparam int FLAG_C  = 1;
    localparam int FLAG_V  = 0;

    typedef struct packed {
        logic             enc_ok;   // pattern matched and usable
        logic             uncond;   // executes without a condition check
        logic [3:0]       cond;     // condition field
        logic [IDX_W-1:0] rd;       // destination index
    } pbadd_dec_t;
endpackage

// File: rtl/pbadd_decode.sv
// Recognises the two encodings of the packed byte-add instruction and
// extracts the destination index and the condition field.
// Assumes the source index fields are not needed (operands arrive as values).
module pbadd_decode
    import pbadd_pkg::*;
(
    input  logic        isa_compact,
    input  logic [31:0] insn,
    output pbadd_dec_t  dec
);
    logic fixed_hit;
    logic compact_hit;

    // Compare the constant fields of each encoding.
    always_comb begin
        fixed_hit   = (insn[27:20] == 8'h65) && (insn[11:8] == 4'hF) &&
                      (insn[7:4] == 4'h9) && (insn[31:28] != 4'hF);
        compact_hit = (insn[31:20] == 12'hFA8) && (insn[15:12] == 4'hF) &&
                      (insn[7:4] == 4'h4);
    end

    // Select the fields for the active encoding.
    always_comb begin
        dec.enc_ok = isa_compact ? compact_hit : fixed_hit;
        dec.uncond = isa_compact;
        dec.cond   = isa_compact ? 4'hE : insn[31:28];
        dec.rd     = isa_compact ? insn[11:8] : insn[15:12];
    end
endmodule

// File: rtl/pbadd_cond.sv
// Evaluates a 4-bit condition code against the NZCV flags.
// Assumes code 0xF never reaches here as executable (decode rejects it).
module pbadd_cond
    import pbadd_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    input  logic       uncond,
    output logic       pass
);
    logic n, z, c, v;
    logic base;

    // Unpack the individual flags.
    always_comb begin
        n = nzcv[FLAG_N];
        z = nzcv[FLAG_Z];
        c = nzcv[FLAG_C];
        v = nzcv[FLAG_V];
    end

    // Condition table; an odd code is the inverse of the even code below it.
    always_comb begin
        case (cond[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c & ~z;
            3'd5:    base = (n == v);
            3'd6:    base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        if (uncond || cond == 4'hE) pass = 1'b1;
        else if (cond == 4'hF)      pass = 1'b0;
        else                        pass = cond[0] ? ~base : base;
    end
endmodule

// File: rtl/pbadd_lanes.sv
// Parallel unsigned lane adder: independent lanes, one carry out per lane.
// Assumes both operands hold NUM_LANES lanes of WIDTH bits each.
module pbadd_lanes #(
    parameter int NUM_LANES = 4,
    parameter int WIDTH     = 8,
    localparam int TOTAL    = NUM_LANES * WIDTH
) (
    input  logic [TOTAL-1:0]     a,
    input  logic [TOTAL-1:0]     b,
    output logic [TOTAL-1:0]     sum,
    output logic [NUM_LANES-1:0] carry
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [WIDTH:0] wide;
        // Zero-extended add confined to this lane.
        always_comb begin
            wide = {1'b0, a[g*WIDTH +: WIDTH]} + {1'b0, b[g*WIDTH +: WIDTH]};
            sum[g*WIDTH +: WIDTH] = wide[WIDTH-1:0];
            carry[g] = wide[WIDTH];
        end
        // A lane wraps exactly when its result is below its first operand.
        always_comb begin
            AST_LANE_WRAP: assert (carry[g] == (sum[g*WIDTH +: WIDTH] < a[g*WIDTH +: WIDTH])); // R2
        end
    end
endmodule

// File: rtl/pbadd_unit.sv
// Packed unsigned byte-add execution slice: decode, condition check,
// lane arithmetic and a registered writeback and flag stage.
// Assumes operand values are already read from the register file.
module pbadd_unit
    import pbadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              isa_compact,
    input  logic [31:0]       insn,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [3:0]        flags_nzcv,
    input  logic [LANES-1:0]  ge_in,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [XLEN-1:0]   wr_data,
    output logic [LANES-1:0]  ge_out,
    output logic [3:0]        nzcv_out,
    output logic              undef
);
    pbadd_dec_t       dec;
    logic             cond_ok;
    logic             exec;
    logic [XLEN-1:0]  lane_sum;
    logic [LANES-1:0] lane_carry;

    pbadd_decode u_dec (
        .isa_compact(isa_compact),
        .insn       (insn),
        .dec        (dec)
    );

    pbadd_cond u_cond (
        .cond  (dec.cond),
        .nzcv  (flags_nzcv),
        .uncond(dec.uncond),
        .pass  (cond_ok)
    );

    pbadd_lanes #(.NUM_LANES(LANES), .WIDTH(LANE_W)) u_lanes (
        .a    (src_a),
        .b    (src_b),
        .sum  (lane_sum),
        .carry(lane_carry)
    );

    // Instruction takes effect only when valid, defined and condition passes.
    always_comb exec = in_valid && dec.enc_ok && cond_ok;

    // Registered result and flag stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            ge_out   <= '0;
            nzcv_out <= '0;
            undef    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            undef <= 1'b0;
            if (in_valid) begin
                undef    <= ~dec.enc_ok;
                nzcv_out <= flags_nzcv;
                if (exec) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= dec.rd;
                    wr_data <= lane_sum;
                    ge_out  <= lane_carry;
                end else begin
                    ge_out  <= ge_in;
                end
            end
        end
    end

    AST_WRITE_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !undef); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !undef)); // R8
    AST_IDLE_HOLD_GE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ge_out)); // R8
    AST_NZCV_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (nzcv_out == $past(flags_nzcv))); // R3
    AST_SKIP_KEEPS_GE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !exec) |=> (!wr_en && ge_out == $past(ge_in))); // R6
endmodule

// File: tb/pbadd_unit_bench.sv
module pbadd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        isa_compact = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [3:0]  flags_nzcv = '0;
    logic [3:0]  ge_in = '0;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic [3:0]  ge_out;
    logic [3:0]  nzcv_out;
    logic        undef;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5ns clk = ~clk;

    pbadd_unit u_pbadd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .isa_compact(isa_compact),
        .insn(insn), .src_a(src_a), .src_b(src_b), .flags_nzcv(flags_nzcv),
        .ge_in(ge_in), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ge_out(ge_out), .nzcv_out(nzcv_out), .undef(undef)
    );

    function automatic logic [31:0] enc_fixed(input logic [3:0] c, input logic [3:0] rn,
                                              input logic [3:0] rd, input logic [3:0] rm);
        return {c, 8'h65, rn, rd, 4'hF, 4'h9, rm};
    endfunction

    function automatic logic [31:0] enc_comp(input logic [3:0] rn, input logic [3:0] rd,
                                             input logic [3:0] rm);
        return {12'hFA8, rn, 4'hF, rd, 4'h4, rm};
    endfunction

    function automatic bit cond_model(input logic [3:0] c, input logic [3:0] f);
        bit n, z, cy, v;
        n = f[3]; z = f[2]; cy = f[1]; v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Present one instruction, then check the registered outputs a clock later.
    task automatic apply(input bit cmp, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [3:0] f, input logic [3:0] g,
                         input string req);
        bit defined, run;
        logic [31:0] esum;
        logic [3:0]  ecar, eidx;
        if (cmp) begin
            defined = ((w & 32'hFFF0F0F0) == 32'hFA80F040);
            run = defined;
            eidx = w[11:8];
        end else begin
            defined = ((w & 32'h0FF00FF0) == 32'h06500F90) && (w[31:28] != 4'hF);
            run = defined && cond_model(w[31:28], f);
            eidx = w[15:12];
        end
        for (int i = 0; i < 4; i++) begin
            logic [8:0] s;
            s = {1'b0, a[i*8 +: 8]} + {1'b0, b[i*8 +: 8]};
            esum[i*8 +: 8] = s[7:0];
            ecar[i] = s[8];
        end
        @(negedge clk);
        in_valid = 1'b1; isa_compact = cmp; insn = w;
        src_a = a; src_b = b; flags_nzcv = f; ge_in = g;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(wr_en == run, req, "wr_en", {31'b0, wr_en}, {31'b0, run});
        chk(undef == !defined, req, "undef", {31'b0, undef}, {31'b0, !defined});
        chk(nzcv_out == f, "R3", "nzcv_out", {28'b0, nzcv_out}, {28'b0, f});
        if (run) begin
            chk(wr_data == esum, "R1", "wr_data", wr_data, esum);
            chk(wr_idx == eidx, req, "wr_idx", {28'b0, wr_idx}, {28'b0, eidx});
            chk(ge_out == ecar, "R2", "ge_out", {28'b0, ge_out}, {28'b0, ecar});
        end else begin
            chk(ge_out == g, req, "ge_out pass", {28'b0, ge_out}, {28'b0, g});
        end
    endtask

    initial begin
        logic [3:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: cleared by reset
        chk({wr_en, undef, wr_idx, ge_out, nzcv_out} == '0 && wr_data == '0, "R9",
            "reset outputs", {wr_en, undef, wr_idx, ge_out, nzcv_out}, 32'h0);
        rst_n = 1'b1;

        // R1 R2: directed lane patterns
        apply(0, enc_fixed(4'hE, 1, 2, 3), 32'h0, 32'h0, 4'h0, 4'hF, "R1");
        for (int l = 0; l < 4; l++)
            apply(0, enc_fixed(4'hE, 4, 5, 6), 32'hFF << (8*l), 32'h01 << (8*l), 4'h0, 4'h0, "R2");
        apply(0, enc_fixed(4'hE, 7, 8, 9), 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h5, 4'h0, "R2");
        apply(0, enc_fixed(4'hE, 1, 15, 2), 32'h80FF7F01, 32'h8001807F, 4'hA, 4'h0, "R1");

        // R6: all condition codes against every NZCV value
        for (int c = 0; c < 15; c++)
            for (int f = 0; f < 16; f++)
                apply(0, enc_fixed(c[3:0], 1, c[3:0], 2), 32'h11223344, 32'hF0E0D0C0,
                      f[3:0], 4'h9, "R6");

        // R4 R7: corrupt each fixed bit; reserved condition
        for (int k = 0; k < 32; k++)
            if (32'h0FF00FF0 & (32'h1 << k))
                apply(0, enc_fixed(4'hE, 3, 4, 5) ^ (32'h1 << k), 32'h1, 32'h2, 4'h0, 4'h6, "R7");
        apply(0, enc_fixed(4'hF, 3, 4, 5), 32'h1, 32'h2, 4'h0, 4'h3, "R7");
        apply(0, enc_fixed(4'h0, 3, 9, 5), 32'hAB, 32'hCD, 4'h4, 4'h3, "R4");

        // R5: compact form ignores NZCV; corrupt its fixed bits
        for (int f = 0; f < 16; f++)
            apply(1, enc_comp(2, 11, 3), 32'hFEDCBA98, 32'h76543210, f[3:0], 4'h0, "R5");
        for (int k = 0; k < 32; k++)
            if (32'hFFF0F0F0 & (32'h1 << k))
                apply(1, enc_comp(2, 11, 3) ^ (32'h1 << k), 32'h5, 32'h6, 4'h0, 4'hC, "R7");
        apply(1, enc_fixed(4'hE, 1, 2, 3), 32'h5, 32'h6, 4'h0, 4'hC, "R7");
        apply(0, enc_comp(1, 2, 3), 32'h5, 32'h6, 4'h0, 4'hC, "R7");

        // R8: idle cycles keep GE and raise nothing
        apply(0, enc_fixed(4'hE, 1, 6, 2), 32'hFF00FF00, 32'h01000100, 4'h0, 4'h0, "R8");
        held = ge_out;
        @(negedge clk); ge_in = 4'h0; insn = enc_fixed(4'hE, 1, 2, 3);
        @(negedge clk);
        chk(!wr_en && !undef, "R8", "idle strobes", {30'b0, wr_en, undef}, 32'h0);
        chk(ge_out == held, "R8", "idle ge hold", {28'b0, ge_out}, {28'b0, held});

        // Random mix of forms, codes and occasional corruption
        for (int t = 0; t < 400; t++) begin
            bit cmp;
            logic [31:0] w;
            cmp = $urandom_range(0, 1) == 1;
            w = cmp ? enc_comp($urandom, $urandom, $urandom)
                    : enc_fixed($urandom, $urandom, $urandom, $urandom);
            if ($urandom_range(0, 9) == 0) w = w ^ (32'h1 << $urandom_range(0, 31));
            apply(cmp, w, $urandom, $urandom, $urandom, $urandom, "R6");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule